// File: doc/BRIEF.md
# Legacy Bridge Integer ALU with Product Extension Register

This block executes the unusual integer operations of an older bridge instruction set in one registered step. It takes up to three 32-bit operands, plus two 32-bit insertion masks for the rotate form, and an operation code. It returns a 32-bit result one clock after the operation is issued. The operations are:

- saturating absolute value
- negative absolute value, with a variant that clears the overflow flag
- signed difference-or-zero
- bitwise mask-insert
- unsigned multiply
- rotate-then-mask-insert
- rotate-sign-bit-insert

The block also holds a 32-bit product extension register. A multiply writes the upper half of its 64-bit product into this register, while the lower half becomes the result. Every other operation leaves the register alone. The register is visible on an output port so that the surrounding pipeline can read it back.

The overflow-recording form of negative absolute value raises a one-cycle strobe. The surrounding core uses this strobe to clear its overflow status bit. The arithmetic result of that form is the same as the plain form.

Top module: `bridge_alu`

## Requirements
- R1: Operation code 0 (absolute value) returns 0x7FFFFFFF for input 0x80000000, the two's complement negation for any other negative operand A, and A unchanged when A is zero or positive.
- R2: Operation codes 1 and 2 (negative absolute value) return the negation of A when A is positive as a signed number, and A unchanged when A is zero or negative.
- R3: The overflow-clear strobe goes high for exactly the cycle in which the result of an operation code 2 appears, and is low after any other operation and in idle cycles.
- R4: Operation code 3 (difference-or-zero) compares A and B as signed numbers and returns B minus A when B is greater than A, otherwise 0.
- R5: Operation code 4 (mask-insert) returns (A AND NOT C) OR (B AND C).
- R6: Operation code 5 (multiply) forms the unsigned 64-bit product A times B, returns bits 31:0 as the result and loads bits 63:32 into the product extension register.
- R7: The product extension register keeps its value across every operation other than code 5 and across cycles without a valid operation.
- R8: Operation code 6 (rotate-mask-insert) rotates A left by C[4:0], ANDs that with the rotate mask, and ORs in B ANDed with the insert mask; bits 31:5 of C are ignored.
- R9: Operation code 7 (rotate-bit-insert) rotates bit 31 of A left by C[4:0] into its target position and takes every other result bit from B; bits 31:5 of C are ignored.
- R10: The result and the valid flag appear on the clock edge after the one at which the operation is accepted. The valid flag stays high for one cycle per accepted operation. Without a valid operation the result holds its last value.
- R11: A synchronous reset clears the result, the valid flag, the overflow-clear strobe and the product extension register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Operation accepted this cycle |
| opSel | input | 3 | Operation code, 0 to 7 as in the requirements |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opC | input | 32 | Third operand: mask for code 4, shift amount for codes 6 and 7 |
| rotMask | input | 32 | Mask applied to the rotated operand (code 6) |
| insMask | input | 32 | Mask applied to operand B (code 6) |
| resValid | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | Registered result |
| ovClr | output | 1 | Overflow-clear strobe for the overflow-recording negative absolute value |
| extOut | output | 32 | Product extension register |

## Verification
A corrupted product extension register shows at the port right away, because it is visible on every cycle. The bench checks it after every operation, so a wrong write enable shows within one operation. The enable might fire on a non-multiply, or fail to fire on a multiply. Faults in the operation decode or in the rotator show on the result one cycle after issue. They are caught by operands whose correct answer depends on sign, on the bit-31 corner, or on the upper bits of the shift operand being ignored. A stuck or misrouted strobe shows in the same cycle as the result of the operation that should or should not raise it.

// File: rtl/bralu_pkg.sv
package bralu_pkg;

  typedef enum logic [2:0] {
    OP_ABS    = 3'd0,
    OP_NABS   = 3'd1,
    OP_NABSV  = 3'd2,
    OP_DOZ    = 3'd3,
    OP_MSKINS = 3'd4,
    OP_MUL    = 3'd5,
    OP_ROTMSK = 3'd6,
    OP_ROTBIT = 3'd7
  } aluOp_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic   issue;   // load the result register
    logic   extWe;   // load the product extension register
    logic   ovClr;   // operation asks for the overflow clear
    aluOp_e sel;     // result selector
  } aluCtrl_t;

endpackage

// File: rtl/bralu_rot.sv
// Logarithmic left rotator; W must be a power of two.
module bralu_rot #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);

  logic [W-1:0] stage [SHW+1];

  assign stage[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int SPAN = 2 ** k;
    assign stage[k+1] = amt[k] ? {stage[k][W-1-SPAN:0], stage[k][W-1:W-SPAN]}
                               : stage[k];
  end

  assign dout = stage[SHW];

endmodule

// File: rtl/bralu_ctrl.sv
module bralu_ctrl
  import bralu_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     opValid,
  input  logic [2:0] opSel,
  output aluCtrl_t ctrl,
  output logic     resValid,
  output logic     ovClr
);

  aluOp_e opCode;

  assign opCode = aluOp_e'(opSel);

  always_comb begin
    ctrl.sel   = opCode;
    ctrl.issue = opValid;
    ctrl.extWe = opValid && (opCode == OP_MUL);
    ctrl.ovClr = opValid && (opCode == OP_NABSV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      ovClr    <= 1'b0;
    end else begin
      resValid <= ctrl.issue;
      ovClr    <= ctrl.ovClr;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    opValid |=> resValid);                                   // R10
  AST_VALID_ONLY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> !resValid);                                 // R10
  AST_OVCLR_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    ovClr |-> resValid);                                     // R3
  AST_OVCLR_ONLY_NABSV: assert property (@(posedge clk) disable iff (rst)
    (opValid && opSel != 3'd2) |=> !ovClr);                  // R3

endmodule

// File: rtl/bralu_dp.sv
module bralu_dp
  import bralu_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  aluCtrl_t     ctrl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  input  logic [W-1:0] rotMask,
  input  logic [W-1:0] insMask,
  output logic [W-1:0] result,
  output logic [W-1:0] extReg
);

  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = ~MIN_NEG;

  logic [W-1:0]   negA;
  logic [W-1:0]   absVal;
  logic [W-1:0]   nabsVal;
  logic [W-1:0]   dozVal;
  logic [W-1:0]   mskVal;
  logic [2*W-1:0] prod;
  logic [SHW-1:0] shAmt;
  logic [W-1:0]   rotIn;
  logic [W-1:0]   rotOut;
  logic [W-1:0]   bitPos;
  logic [W-1:0]   rotMskVal;
  logic [W-1:0]   rotBitVal;
  logic [W-1:0]   nextRes;

  assign negA = ~opA + {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (opA == MIN_NEG)   absVal = MAX_POS;
    else if (opA[W-1])    absVal = negA;
    else                  absVal = opA;
  end

  assign nabsVal = (!opA[W-1] && (opA != '0)) ? negA : opA;
  assign dozVal  = ($signed(opB) > $signed(opA)) ? (opB - opA) : '0;
  assign mskVal  = (opA & ~opC) | (opB & opC);
  assign prod    = {{W{1'b0}}, opA} * {{W{1'b0}}, opB};

  // One rotator serves both rotate forms
  assign shAmt = opC[SHW-1:0];
  assign rotIn = (ctrl.sel == OP_ROTBIT) ? (opA & MIN_NEG) : opA;

  bralu_rot #(.W(W)) u_rot (
    .din  (rotIn),
    .amt  (shAmt),
    .dout (rotOut)
  );

  // Position the sign bit lands on: bit (amt-1) mod W
  for (genvar i = 0; i < W; i++) begin : g_bitpos
    localparam logic [SHW-1:0] HIT = SHW'((i + 1) % W);
    assign bitPos[i] = (shAmt == HIT);
  end

  assign rotMskVal = (rotOut & rotMask) | (opB & insMask);
  assign rotBitVal = (rotOut & bitPos) | (opB & ~bitPos);

  always_comb begin
    unique case (ctrl.sel)
      OP_ABS:    nextRes = absVal;
      OP_NABS,
      OP_NABSV:  nextRes = nabsVal;
      OP_DOZ:    nextRes = dozVal;
      OP_MSKINS: nextRes = mskVal;
      OP_MUL:    nextRes = prod[W-1:0];
      OP_ROTMSK: nextRes = rotMskVal;
      OP_ROTBIT: nextRes = rotBitVal;
      default:   nextRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      extReg <= '0;
    end else begin
      if (ctrl.issue) result <= nextRes;
      if (ctrl.extWe) extReg <= prod[2*W-1:W];
    end
  end

  AST_ABS_NOT_NEG: assert property (@(posedge clk) disable iff (rst)
    (ctrl.issue && ctrl.sel == OP_ABS) |=> !result[W-1]);               // R1
  AST_NABS_NOT_POS: assert property (@(posedge clk) disable iff (rst)
    (ctrl.issue && (ctrl.sel == OP_NABS || ctrl.sel == OP_NABSV))
      |=> (result[W-1] || result == '0));                                // R2
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.issue && ctrl.sel == OP_MUL) |=> $stable(extReg));            // R7
  AST_MUL_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (ctrl.issue && ctrl.sel == OP_MUL && opB == {{(W-1){1'b0}}, 1'b1})
      |=> (result == $past(opA) && extReg == '0));                       // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.issue |=> $stable(result));                                    // R10

endmodule

// File: rtl/bridge_alu.sv
module bridge_alu
  import bralu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         opValid,
  input  logic [2:0]   opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  input  logic [W-1:0] rotMask,
  input  logic [W-1:0] insMask,
  output logic         resValid,
  output logic [W-1:0] result,
  output logic         ovClr,
  output logic [W-1:0] extOut
);

  aluCtrl_t ctrl;

  bralu_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opValid  (opValid),
    .opSel    (opSel),
    .ctrl     (ctrl),
    .resValid (resValid),
    .ovClr    (ovClr)
  );

  bralu_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .opC     (opC),
    .rotMask (rotMask),
    .insMask (insMask),
    .result  (result),
    .extReg  (extOut)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!resValid && !ovClr && result == '0 && extOut == '0));     // R11

endmodule

// File: tb/bridge_alu_tb_top.sv
module bridge_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [31:0] opA = '0, opB = '0, opC = '0, rotMask = '0, insMask = '0;
  logic        resValid, ovClr;
  logic [31:0] result, extOut;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bridge_alu dut_i (
    .clk(clk), .rst(rst), .opValid(opValid), .opSel(opSel),
    .opA(opA), .opB(opB), .opC(opC), .rotMask(rotMask), .insMask(insMask),
    .resValid(resValid), .result(result), .ovClr(ovClr), .extOut(extOut)
  );

  localparam int NV = 19;
  localparam logic [2:0] V_OP [NV] = '{
    3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd3, 3'd3, 3'd3, 3'd3,
    3'd4, 3'd5, 3'd5, 3'd0, 3'd6, 3'd6, 3'd7, 3'd7, 3'd7 };
  localparam logic [31:0] V_A [NV] = '{
    32'h80000000, 32'hFFFFFFFB, 32'h00001234, 32'h00000005, 32'hFFFFFFF0,
    32'h00000000, 32'h00000003, 32'h0000000A, 32'hFFFFFFFF, 32'h00000005,
    32'hAAAAAAAA, 32'h00010000, 32'hFFFFFFFF, 32'h00000007, 32'h12345678,
    32'h0000000F, 32'h80000000, 32'h00000000, 32'h80000000 };
  localparam logic [31:0] V_B [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0000000A, 32'h00000003, 32'h00000001, 32'h00000005,
    32'h55555555, 32'h00010000, 32'h00000003, 32'h0, 32'hAABBCCDD,
    32'h12345678, 32'h00000000, 32'hFFFFFFFF, 32'h0000FFFF };
  localparam logic [31:0] V_C [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0000FFFF, 32'h0, 32'h0, 32'h0, 32'h00000008,
    32'h00000024, 32'h00000001, 32'h0000003F, 32'h00000000 };
  localparam logic [31:0] V_RM [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFFFF00, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0 };
  localparam logic [31:0] V_IM [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h000000FF, 32'h00000000, 32'h0, 32'h0, 32'h0 };
  localparam logic [31:0] V_RES [NV] = '{
    32'h7FFFFFFF, 32'h00000005, 32'h00001234, 32'hFFFFFFFB, 32'hFFFFFFF0,
    32'h00000000, 32'h00000007, 32'h00000000, 32'h00000002, 32'h00000000,
    32'hAAAA5555, 32'h00000000, 32'hFFFFFFFD, 32'h00000007, 32'h345678DD,
    32'h000000F0, 32'h00000001, 32'hBFFFFFFF, 32'h8000FFFF };
  localparam logic [31:0] V_EXT [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h00000001, 32'h00000002, 32'h00000002, 32'h00000002,
    32'h00000002, 32'h00000002, 32'h00000002, 32'h00000002 };

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R2 R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    opValid = 1'b0; opSel = 3'd0;
    opA = '0; opB = '0; opC = '0; rotMask = '0; insMask = '0;
  endtask

  initial begin
    // Reset state (R11)
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 result after reset", result, 32'h0);
    chk("R11 resValid after reset", {31'h0, resValid}, 32'h0);
    chk("R11 ovClr after reset", {31'h0, ovClr}, 32'h0);
    chk("R11 ext after reset", extOut, 32'h0);

    // Vector table, issued back to back
    for (int i = 0; i < NV; i++) begin
      opValid = 1'b1; opSel = V_OP[i];
      opA = V_A[i]; opB = V_B[i]; opC = V_C[i];
      rotMask = V_RM[i]; insMask = V_IM[i];
      @(negedge clk);
      chk({tagOf(V_OP[i]), " result"}, result, V_RES[i]);
      chk("R10 resValid after issue", {31'h0, resValid}, 32'h1);
      chk("R3 ovClr", {31'h0, ovClr}, {31'h0, (V_OP[i] == 3'd2)});
      chk((V_OP[i] == 3'd5) ? "R6 ext" : "R7 ext", extOut, V_EXT[i]);
    end

    // Idle cycle with multiply operands present: nothing may move (R7, R10)
    opValid = 1'b0; opSel = 3'd5; opA = 32'hFFFFFFFF; opB = 32'hFFFFFFFF;
    @(negedge clk);
    chk("R10 resValid low when idle", {31'h0, resValid}, 32'h0);
    chk("R10 result holds when idle", result, 32'h8000FFFF);
    chk("R7 ext holds when idle", extOut, 32'h00000002);
    chk("R3 ovClr low when idle", {31'h0, ovClr}, 32'h0);

    // Strobe is a single pulse: NABSV then ABS
    opValid = 1'b1; opSel = 3'd2; opA = 32'h00000001; opB = '0;
    @(negedge clk);
    chk("R3 ovClr pulse", {31'h0, ovClr}, 32'h1);
    chk("R3 nabs of 1", result, 32'hFFFFFFFF);
    opSel = 3'd0;
    @(negedge clk);
    chk("R3 ovClr drops", {31'h0, ovClr}, 32'h0);
    chk("R1 abs of 1", result, 32'h00000001);

    // Large multiply then synchronous reset clears everything (R6, R11)
    opSel = 3'd5; opA = 32'hFFFFFFFF; opB = 32'hFFFFFFFF;
    @(negedge clk);
    chk("R6 max product low", result, 32'h00000001);
    chk("R6 max product high", extOut, 32'hFFFFFFFE);
    idleInputs();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 ext cleared", extOut, 32'h0);
    chk("R11 result cleared", result, 32'h0);
    chk("R11 resValid cleared", {31'h0, resValid}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule